// File: doc/BRIEF.md
# Channel Fault Auto-Retry Controller

This block decides how one output channel reacts to protective faults that can be latched: overcurrent, hard short, overtemperature and supply undervoltage. When such a fault appears while the channel is commanded on, the channel is switched off. With retry enabled, it is switched back on after a programmable off time. Each attempt is counted, and once the attempts are used up the channel is held off for good.

A held-off channel is released in one of two ways. The control signal can go low and then high again, or one of the system events that clear the attempt counter can occur. The block takes the fault flags from separate sensing logic. It takes the channel control signal from the mode logic.

Retry is enabled when a configuration pin and a retry bit agree. A mode bit allows unlimited attempts. A 2-bit field picks one of four off-time lengths. The outputs are the channel enable, a latched flag, a counter-full flag, the attempt count and an active-low fault line.

Top module: `fault_retry_ctrl`

## Requirements
- R1: Retry is enabled exactly when `cfg_pin_i` equals `retry_bit_i` (0/0 or 1/1). When they differ, retry is disabled.
- R2: While the channel is running and `fc_i` (seen one clock late) is high, `chan_en_o` is 1 only when none of `oc_i`, `sc_i`, `ot_i` or `uv_i` is high. A fault flag drops `chan_en_o` in the same cycle.
- R3: With retry enabled, a fault seen while running sends the channel to an off wait. After the wait it runs again. The wait lasts PER0, PER1, PER2 or PER3 cycles for `period_sel_i` = 0, 1, 2 or 3. While `ot_i` or `uv_i` is high the wait restarts, so the full off time counts from the moment both are clear.
- R4: With `unlimited_i` = 0, each retry adds one to `retry_cnt_o`. The count saturates at 15. The 15th retry sets `rfull_o`. A 16th retry is still made. A fault seen after that 16th retry latches the channel.
- R5: With `unlimited_i` = 1 and retry enabled, the channel never latches, however long the fault lasts.
- R6: With retry disabled, a fault seen while running latches the channel at the next clock.
- R7: A rising edge of the registered `fc_i` releases the channel to run, whether it is latched or waiting. A release during a wait leaves `retry_cnt_o` and `rfull_o` unchanged.
- R8: Any of the following clears the count, `rfull_o` and the final-try flag:
  - `failsafe_entry_i`, `sleep_exit_i` or `por_i`;
  - a 0-to-1 change of `unlimited_i`;
  - a change of the retry enable from enabled to disabled.
  
  If the channel was latched when the clear happens, it enters a wait of one period and then runs.
- R9: `latched_o` is 1 only while the channel is held off. `fault_no` is low while any fault flag is high or the channel is latched, and high otherwise.
- R10: After reset the channel is running and enable depends only on `fc_i` and the fault flags. The count is 0 and `rfull_o` and `latched_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc_i | input | 1 | Overcurrent flag |
| sc_i | input | 1 | Severe short flag |
| ot_i | input | 1 | Overtemperature flag |
| uv_i | input | 1 | Supply undervoltage flag |
| fc_i | input | 1 | Channel fault-control / on-command signal |
| cfg_pin_i | input | 1 | Application configuration pin |
| retry_bit_i | input | 1 | Retry bit (enable when equal to cfg_pin_i) |
| unlimited_i | input | 1 | Unlimited-retry mode |
| period_sel_i | input | 2 | Off-time select |
| failsafe_entry_i | input | 1 | Pulse: fail-safe entered |
| sleep_exit_i | input | 1 | Pulse: sleep left |
| por_i | input | 1 | Pulse: power-on reset event |
| chan_en_o | output | 1 | Channel switch enable |
| latched_o | output | 1 | Channel latched off |
| rfull_o | output | 1 | Retry count reached 15 |
| retry_cnt_o | output | CNT_W | Retry count |
| fault_no | output | 1 | Fault indication, active low |

## Verification
`chan_en_o` and `fault_no` respond to the fault flags in the same cycle. `fc_i` passes through one register before it has any effect. State changes such as wait entry, latching, release and counter updates show up one clock after the edge that sees their cause. A wait of period P therefore keeps the channel off for exactly P cycles.

The bench drives inputs and samples all outputs on the falling edge. It compares them every cycle against a behavioural model that advances on the rising edge. Every latency is thus checked at the exact cycle it is due, not inside a window.

// File: rtl/fault_retry_pkg.sv
package fault_retry_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LATCH = 2'd2
  } retry_st_e;
endpackage

// File: rtl/fr_fc_track.sv
module fr_fc_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fc_i,
  output logic fc_q_o,
  output logic rise_o
);
  logic fc_q, fc_qq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fc_q  <= 1'b0;
      fc_qq <= 1'b0;
    end else begin
      fc_q  <= fc_i;
      fc_qq <= fc_q;
    end
  end

  // a rise after a low: the 0-1 tail of the 1-0-1 release pattern
  assign rise_o = fc_q & ~fc_qq;
  assign fc_q_o = fc_q;
endmodule

// File: rtl/fr_period_timer.sv
module fr_period_timer #(
  parameter int unsigned PER0 = 3,
  parameter int unsigned PER1 = 5,
  parameter int unsigned PER2 = 8,
  parameter int unsigned PER3 = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       hold_i,
  input  logic [1:0] sel_i,
  output logic       expired_o
);
  localparam int unsigned PMAX01 = (PER0 > PER1) ? PER0 : PER1;
  localparam int unsigned PMAX23 = (PER2 > PER3) ? PER2 : PER3;
  localparam int unsigned PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
  localparam int unsigned TW     = $clog2(PMAX + 1);

  logic [TW-1:0] tmr_q;
  logic [TW-1:0] reload;

  always_comb begin
    unique case (sel_i)
      2'd0:    reload = TW'(PER0 - 1);
      2'd1:    reload = TW'(PER1 - 1);
      2'd2:    reload = TW'(PER2 - 1);
      default: reload = TW'(PER3 - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (load_i || hold_i)  tmr_q <= reload;
    else if (tmr_q != '0)       tmr_q <= tmr_q - 1'b1;
  end

  assign expired_o = (tmr_q == '0);

  // R3: a freshly started wait never ends on the next cycle (periods >= 2)
  a_r3_no_instant_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i || hold_i) |=> !expired_o);
endmodule

// File: rtl/fr_retry_count.sv
module fr_retry_count #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             final_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             full_q, final_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      final_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      final_q <= 1'b0;
    end else if (step_i) begin
      if (cnt_q != CMAX) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CMAX - 1'b1) full_q <= 1'b1;
      end else begin
        final_q <= 1'b1;  // the one extra attempt is being used
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign full_o  = full_q;
  assign final_o = final_q;

  a_r4_final_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    final_o |-> full_o);
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CMAX && !clr_i) |=> cnt_o == CMAX);
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl
  import fault_retry_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned PER0  = 3,
  parameter int unsigned PER1  = 5,
  parameter int unsigned PER2  = 8,
  parameter int unsigned PER3  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oc_i,
  input  logic             sc_i,
  input  logic             ot_i,
  input  logic             uv_i,
  input  logic             fc_i,
  input  logic             cfg_pin_i,
  input  logic             retry_bit_i,
  input  logic             unlimited_i,
  input  logic [1:0]       period_sel_i,
  input  logic             failsafe_entry_i,
  input  logic             sleep_exit_i,
  input  logic             por_i,
  output logic             chan_en_o,
  output logic             latched_o,
  output logic             rfull_o,
  output logic [CNT_W-1:0] retry_cnt_o,
  output logic             fault_no
);
  retry_st_e st_q, st_d;
  logic fc_q, fc_rise, expired, cnt_final;
  logic retry_en, en_q, unl_q;
  logic fault_any, thermal, cnt_clr, retry_fire, tmr_load, tmr_hold;

  fr_fc_track i_fc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fc_i   (fc_i),
    .fc_q_o (fc_q),
    .rise_o (fc_rise)
  );

  assign fault_any = oc_i | sc_i | ot_i | uv_i;
  assign thermal   = ot_i | uv_i;
  assign retry_en  = ~(cfg_pin_i ^ retry_bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      unl_q <= 1'b0;
    end else begin
      en_q  <= retry_en;
      unl_q <= unlimited_i;
    end
  end

  assign cnt_clr = failsafe_entry_i | sleep_exit_i | por_i
                 | (unlimited_i & ~unl_q) | (en_q & ~retry_en);

  always_comb begin
    st_d       = st_q;
    retry_fire = 1'b0;
    if (cnt_clr && st_q == ST_LATCH) begin
      st_d = ST_WAIT;
    end else if (fc_rise && st_q != ST_RUN) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN: if (fc_q && fault_any)
                  st_d = (!retry_en || (!unlimited_i && cnt_final)) ? ST_LATCH : ST_WAIT;
        ST_WAIT: if (!thermal && expired) begin
                  st_d       = ST_RUN;
                  retry_fire = 1'b1;
                end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign tmr_load = (st_d == ST_WAIT) && (st_q != ST_WAIT);
  assign tmr_hold = (st_q == ST_WAIT) && thermal;

  fr_period_timer #(
    .PER0 (PER0), .PER1 (PER1), .PER2 (PER2), .PER3 (PER3)
  ) i_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .hold_i    (tmr_hold),
    .sel_i     (period_sel_i),
    .expired_o (expired)
  );

  fr_retry_count #(.CNT_W (CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .step_i  (retry_fire & ~unlimited_i),
    .cnt_o   (retry_cnt_o),
    .full_o  (rfull_o),
    .final_o (cnt_final)
  );

  assign chan_en_o = (st_q == ST_RUN) & fc_q & ~fault_any;
  assign latched_o = (st_q == ST_LATCH);
  assign fault_no  = ~(fault_any | latched_o);

  a_r5_unlimited_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlimited_i && retry_en && !latched_o) |=> !latched_o);
  a_r6_disabled_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retry_en && st_q == ST_RUN && fc_q && fault_any) |=> latched_o);
  a_r7_release_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && fc_rise && !cnt_clr) |=> (retry_cnt_o == $past(retry_cnt_o)));
  a_r8_clear_unlatches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && cnt_clr) |=> (!latched_o && !chan_en_o && retry_cnt_o == '0));
  a_r9_latched_flags_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |-> !fault_no);
endmodule

// File: tb/test_fault_retry_ctrl.sv
module test_fault_retry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc = 0, sc = 0, ot = 0, uv = 0, fc = 0;
  logic cfg = 0, rbit = 0, unl = 0;
  logic [1:0] sel = 2'd0;
  logic fs = 0, slx = 0, por = 0;
  logic chan_en, latched, rfull, fault_n;
  logic [3:0] cnt;

  int tests = 0, fails = 0;
  string cur_req = "R10";
  bit done = 0;

  always #5 clk = ~clk;

  fault_retry_ctrl #(.CNT_W(4), .PER0(3), .PER1(5), .PER2(8), .PER3(12)) i_fault_retry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .oc_i(oc), .sc_i(sc), .ot_i(ot), .uv_i(uv),
    .fc_i(fc), .cfg_pin_i(cfg), .retry_bit_i(rbit), .unlimited_i(unl),
    .period_sel_i(sel), .failsafe_entry_i(fs), .sleep_exit_i(slx), .por_i(por),
    .chan_en_o(chan_en), .latched_o(latched), .rfull_o(rfull),
    .retry_cnt_o(cnt), .fault_no(fault_n));

  // behavioural reference: 0 running, 1 off-wait, 2 held off
  int per[4] = '{3, 5, 8, 12};
  int m_st, m_tmr, m_cnt;
  bit m_full, m_fin, m_fc1, m_fc2, m_en_prev, m_unl_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tmr = 0; m_cnt = 0; m_full = 0; m_fin = 0;
      m_fc1 = 0; m_fc2 = 0; m_en_prev = 0; m_unl_prev = 0;
    end else begin
      bit flt, hot, en, rise, clr, fire;
      int nst;
      flt  = oc | sc | ot | uv;
      hot  = ot | uv;
      en   = (cfg == rbit);
      rise = m_fc1 && !m_fc2;
      clr  = fs || slx || por || (unl && !m_unl_prev) || (m_en_prev && !en);
      fire = 0;
      nst  = m_st;
      if (clr && m_st == 2) nst = 1;
      else if (rise && m_st != 0) nst = 0;
      else if (m_st == 0) begin
        if (m_fc1 && flt) nst = (!en || (!unl && m_fin)) ? 2 : 1;
      end else if (m_st == 1) begin
        if (!hot && m_tmr == 0) begin nst = 0; fire = 1; end
      end
      if ((nst == 1 && m_st != 1) || (m_st == 1 && hot)) m_tmr = per[sel] - 1;
      else if (m_tmr > 0) m_tmr--;
      if (clr) begin m_cnt = 0; m_full = 0; m_fin = 0; end
      else if (fire && !unl) begin
        if (m_cnt < 15) begin m_cnt++; if (m_cnt == 15) m_full = 1; end
        else m_fin = 1;
      end
      m_st = nst;
      m_fc2 = m_fc1; m_fc1 = fc;
      m_en_prev = en; m_unl_prev = unl;
    end
  end

  task automatic check();
    bit e_en, e_lat, e_fn;
    e_en  = (m_st == 0) && m_fc1 && !(oc | sc | ot | uv);
    e_lat = (m_st == 2);
    e_fn  = !((oc | sc | ot | uv) || e_lat);
    tests++;
    if (chan_en !== e_en || latched !== e_lat || rfull !== m_full ||
        cnt !== 4'(m_cnt) || fault_n !== e_fn) begin
      fails++;
      $display("FAIL %s t=%0t en=%b/%b lat=%b/%b full=%b/%b cnt=%0d/%0d fn=%b/%b (actual/expected)",
               cur_req, $time, chan_en, e_en, latched, e_lat, rfull, m_full,
               cnt, m_cnt, fault_n, e_fn);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check();
    end
  endtask

  task automatic pulse_fc_low(int n);
    fc = 0; cyc(n); fc = 1;
  endtask

  initial begin
    cur_req = "R10"; cyc(3);            // reset state
    rst_n = 1; cyc(2);
    fc = 1; cyc(3);
    cur_req = "R2"; oc = 1; cyc(1);     // same-cycle drop
    cur_req = "R3"; oc = 0; cyc(6);     // 3-cycle wait, retry
    sel = 2'd2; sc = 1; cyc(1); sc = 0; cyc(12);
    sel = 2'd3; uv = 1; cyc(1); cyc(7); uv = 0; cyc(16); // wait restarts until clear
    sel = 2'd1; ot = 1; cyc(9); ot = 0; cyc(10);
    cur_req = "R4"; sel = 2'd0; oc = 1; cyc(80); oc = 0; cyc(3);
    cur_req = "R9"; cyc(2); oc = 1; cyc(1); oc = 0; cyc(2);
    cur_req = "R7"; pulse_fc_low(3); cyc(4);  // release from latch
    oc = 1; cyc(3); oc = 0; cyc(3);           // final flag still set: latch again
    cur_req = "R8"; por = 1; cyc(1); por = 0; cyc(6);
    oc = 1; cyc(2); oc = 0; cyc(6);
    cur_req = "R7"; sel = 2'd3; oc = 1; cyc(2); oc = 0; pulse_fc_low(2); cyc(5);
    cur_req = "R5"; sel = 2'd0; unl = 1; oc = 1; cyc(90); oc = 0; cyc(6);
    unl = 0; cyc(2);
    cur_req = "R1"; cfg = 1; rbit = 0; cyc(2);  // mismatch: disabled, counter cleared
    cur_req = "R6"; oc = 1; cyc(2); oc = 0; cyc(3);
    cur_req = "R7"; pulse_fc_low(2); cyc(3);
    cur_req = "R1"; rbit = 1; cyc(2); oc = 1; cyc(1); oc = 0; cyc(6);
    cur_req = "R6"; cfg = 0; sc = 1; cyc(2); sc = 0; cyc(2);
    cur_req = "R8"; cfg = 1; cyc(1); fs = 1; cyc(1); fs = 0; cyc(5);
    oc = 1; cyc(40); oc = 0; cyc(2);
    slx = 1; cyc(1); slx = 0; cyc(8);
    oc = 1; cyc(2); oc = 0; unl = 1; cyc(1); unl = 0; cyc(6);
    cur_req = "R2"; fc = 0; oc = 1; cyc(3); oc = 0; fc = 1; cyc(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule